// File: doc/BRIEF.md
# Video-Mode Line and Frame Timing Sequencer

This block paces a display-serial video-mode transmitter. It counts horizontal time in link byte-clock cycles and vertical time in lines. From a small set of timing words it produces the event stream that a packet builder and a pixel fetch unit need: a strobe at the start of every line and every frame, the current vertical region, horizontal sync, back-porch and front-porch windows, the start and extent of every pixel packet and null packet, a flag that allows the lanes to fall back to low power, and a per-line pixel fetch strobe.

The timing words are copied into shadow registers only while the soft reset input is low. Counting begins on the first cycle after soft reset is released, and that cycle is cycle 0 of line 0 of a frame. An active line can be sent as one burst packet, or split into several equal pixel chunks, each followed by an optional null packet.

Top module: `dsi_vid_seq`

## Requirements
- R1: Field positions: `cfg_hblank` holds the back-porch cycles in bits 15:0 and the sync cycles in bits 31:16; `cfg_vblank` holds front-porch lines in bits 9:0, back-porch lines in bits 19:10 and sync lines in bits 29:20; `cfg_pkt` holds the packet payload count in bits 15:0 and the chunk count in bits 31:16.
- R2: Every line lasts exactly `cfg_line_time` cycles, and `line_start` pulses for one cycle on the first cycle of each line, starting with the first cycle after soft reset release.
- R3: A frame is made of sync lines, then back-porch lines, then active lines, then front-porch lines. A region with a count of zero is skipped. `frame_start` pulses on the first cycle of the first line of each frame. `vregion` reports 0 for sync, 1 for back porch, 2 for active and 3 for front porch.
- R4: On active lines the first pixel packet starts at cycle sync+back-porch of the line. Each pixel packet occupies payload+6 cycles, and `pix_pkt_start` pulses on its first cycle.
- R5: With a chunk count N>0, N pixel packets go out back to back. When the null size is non-zero, each of them is followed directly by a null packet of null-size+6 cycles, and `null_pkt_start` pulses on its first cycle.
- R6: With a chunk count of 0, each active line carries exactly one pixel packet and no null packet, whatever the null size.
- R7: A packet that would start at or after the line end is not sent. A line that is still busy at the line end is cut off, and the next line starts its sequence afresh.
- R8: On sync, back-porch and front-porch lines, `lp_allowed` is 0 inside the horizontal sync window. After that window it equals the region's enable: `cfg_lp_en[0]` for sync, `[1]` for back porch, `[2]` for front porch.
- R9: On active lines, `lp_allowed` is 1 only when `cfg_lp_en[3]` is set and either the cycle is in the back-porch window with `cfg_lp_en[4]` set, or the cycle is after the last packet with `cfg_lp_en[5]` set.
- R10: On active lines only, `fetch_start` pulses at cycle `cfg_fetch_dly` of the line. It never pulses if that delay is not below the line time.
- R11: Timing inputs are sampled only while `soft_rst_n` is low. Changes while it is high have no effect, and pulling it low returns the sequencer to the start of a frame.
- R12: While `rst_n` or `soft_rst_n` keeps the block stopped, every strobe and window output and `lp_allowed` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst_n | input | 1 | Low: stop and load timing; high: run |
| cfg_hblank | input | 32 | Horizontal sync and back-porch cycles |
| cfg_line_time | input | 16 | Total line length in cycles |
| cfg_vblank | input | 30 | Vertical sync, back and front porch lines |
| cfg_vactive | input | 16 | Active line count |
| cfg_pkt | input | 32 | Packet payload count and chunk count |
| cfg_null_size | input | 10 | Null packet payload size |
| cfg_lp_en | input | 6 | Low-power enables per region |
| cfg_fetch_dly | input | 24 | Pixel fetch offset within an active line |
| line_start | output | 1 | First cycle of a line |
| frame_start | output | 1 | First cycle of a frame |
| vregion | output | 2 | Current vertical region |
| hsync_win | output | 1 | Inside horizontal sync window |
| hbp_win | output | 1 | Inside horizontal back porch of an active line |
| hfp_win | output | 1 | After the last packet of an active line |
| pix_pkt_start | output | 1 | First cycle of a pixel packet |
| pix_pkt_busy | output | 1 | Pixel packet in progress |
| null_pkt_start | output | 1 | First cycle of a null packet |
| null_pkt_busy | output | 1 | Null packet in progress |
| lp_allowed | output | 1 | Lanes may drop to low power |
| fetch_start | output | 1 | Upstream pixel request strobe |

## Verification
The bench targets four cases. A zero back porch and zero sync makes the first packet coincide with soft reset release; a sequencer that starts its packet engine one cycle late misses that packet. Zero-length vertical regions must be skipped without a stall line, and a chunked line that overruns the line time must be cut off without leaking a stale packet into the next line. A non-zero null size under burst operation must produce no null packets. Changing the timing inputs while running must leave every event where the shadowed values put it, and low-power windows on active and blanking lines are compared every cycle against an independent per-cycle model.

// File: rtl/dsi_vseq_pkg.sv
package dsi_vseq_pkg;

  // Vertical regions, listed in frame order.
  typedef enum logic [1:0] {
    VR_SYNC  = 2'd0,
    VR_BACK  = 2'd1,
    VR_ACT   = 2'd2,
    VR_FRONT = 2'd3
  } vreg_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PIX  = 2'd1,
    PH_NULL = 2'd2
  } hphase_e;

  localparam int unsigned PKT_OVERHEAD = 6;

  // Cycles a packet holds the link: payload plus fixed header/footer bytes.
  function automatic int unsigned pkt_span(input int unsigned payload);
    return payload + PKT_OVERHEAD;
  endfunction

endpackage

// File: rtl/vseq_cfg.sv
module vseq_cfg #(
  parameter int H_W    = 16,
  parameter int V_W    = 10,
  parameter int VACT_W = 16,
  parameter int NULL_W = 10,
  parameter int DLY_W  = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst_n,
  input  logic [2*H_W-1:0]    cfg_hblank,
  input  logic [H_W-1:0]      cfg_line_time,
  input  logic [3*V_W-1:0]    cfg_vblank,
  input  logic [VACT_W-1:0]   cfg_vactive,
  input  logic [2*H_W-1:0]    cfg_pkt,
  input  logic [NULL_W-1:0]   cfg_null_size,
  input  logic [5:0]          cfg_lp_en,
  input  logic [DLY_W-1:0]    cfg_fetch_dly,
  output logic                run,
  output logic [H_W-1:0]      hsa,
  output logic [H_W-1:0]      hbp,
  output logic [H_W-1:0]      line_time,
  output logic [V_W-1:0]      vsa,
  output logic [V_W-1:0]      vbp,
  output logic [V_W-1:0]      vfp,
  output logic [VACT_W-1:0]   vact,
  output logic [H_W-1:0]      pkt_size,
  output logic [H_W-1:0]      chunks,
  output logic [NULL_W-1:0]   null_size,
  output logic [5:0]          lp_en,
  output logic [DLY_W-1:0]    fetch_dly
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run       <= 1'b0;
      hsa       <= '0;
      hbp       <= '0;
      line_time <= '0;
      vsa       <= '0;
      vbp       <= '0;
      vfp       <= '0;
      vact      <= '0;
      pkt_size  <= '0;
      chunks    <= '0;
      null_size <= '0;
      lp_en     <= '0;
      fetch_dly <= '0;
    end else begin
      run <= soft_rst_n;
      if (!soft_rst_n) begin
        hbp       <= cfg_hblank[H_W-1:0];
        hsa       <= cfg_hblank[2*H_W-1:H_W];
        line_time <= cfg_line_time;
        vfp       <= cfg_vblank[V_W-1:0];
        vbp       <= cfg_vblank[2*V_W-1:V_W];
        vsa       <= cfg_vblank[3*V_W-1:2*V_W];
        vact      <= cfg_vactive;
        pkt_size  <= cfg_pkt[H_W-1:0];
        chunks    <= cfg_pkt[2*H_W-1:H_W];
        null_size <= cfg_null_size;
        lp_en     <= cfg_lp_en;
        fetch_dly <= cfg_fetch_dly;
      end
    end
  end

  // R11
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> $stable({hsa, hbp, line_time, vsa, vbp, vfp, vact, pkt_size,
                     chunks, null_size, lp_en, fetch_dly}));

endmodule

// File: rtl/vseq_vert.sv
module vseq_vert
  import dsi_vseq_pkg::*;
#(
  parameter int V_W    = 10,
  parameter int VACT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst_n,
  input  logic              run,
  input  logic              line_end,
  input  logic [V_W-1:0]    vsa,
  input  logic [V_W-1:0]    vbp,
  input  logic [VACT_W-1:0] vact,
  input  logic [V_W-1:0]    vfp,
  output vreg_e             vreg,
  output vreg_e             vreg_nxt,
  output logic              frame_head
);

  localparam int CW = (V_W > VACT_W) ? V_W : VACT_W;

  logic [CW-1:0] cnt_of [4];
  logic [3:0]    nz;
  logic [CW-1:0] vcnt, vcnt_nxt;
  logic          last_line;
  vreg_e         first_reg;

  // Next region in frame order whose line count is non-zero.
  function automatic vreg_e step_region(input vreg_e cur, input logic [3:0] nzm);
    vreg_e pick;
    logic  hit;
    pick = VR_FRONT;
    hit  = 1'b0;
    for (int i = 1; i <= 4; i++) begin
      logic [1:0] c;
      c = 2'(int'(cur) + i);
      if (!hit && nzm[c]) begin
        pick = vreg_e'(c);
        hit  = 1'b1;
      end
    end
    return pick;
  endfunction

  assign cnt_of[0] = CW'(vsa);
  assign cnt_of[1] = CW'(vbp);
  assign cnt_of[2] = CW'(vact);
  assign cnt_of[3] = CW'(vfp);

  generate
    for (genvar g = 0; g < 4; g++) begin : g_nz
      assign nz[g] = (cnt_of[g] != '0);
    end
  endgenerate

  assign first_reg  = step_region(VR_FRONT, nz);
  assign last_line  = ({1'b0, vcnt} + 1'b1) >= {1'b0, cnt_of[vreg]};
  assign frame_head = (vcnt == '0) && (vreg == first_reg);

  always_comb begin
    vreg_nxt = vreg;
    vcnt_nxt = vcnt;
    if (!soft_rst_n) begin
      vreg_nxt = first_reg;
      vcnt_nxt = '0;
    end else if (run && line_end) begin
      if (last_line) begin
        vreg_nxt = step_region(vreg, nz);
        vcnt_nxt = '0;
      end else begin
        vcnt_nxt = vcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vreg <= VR_SYNC;
      vcnt <= '0;
    end else begin
      vreg <= vreg_nxt;
      vcnt <= vcnt_nxt;
    end
  end

  // R3
  region_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && vreg != $past(vreg)) |-> $past(line_end));

endmodule

// File: rtl/vseq_horiz.sv
module vseq_horiz
  import dsi_vseq_pkg::*;
#(
  parameter int H_W    = 16,
  parameter int NULL_W = 10,
  parameter int DLY_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst_n,
  input  logic              run,
  input  logic              active_now,
  input  logic              active_nxt,
  input  logic [H_W-1:0]    hsa,
  input  logic [H_W-1:0]    hbp,
  input  logic [H_W-1:0]    line_time,
  input  logic [H_W-1:0]    pkt_size,
  input  logic [H_W-1:0]    chunks,
  input  logic [NULL_W-1:0] null_size,
  input  logic [DLY_W-1:0]  fetch_dly,
  output logic              line_end,
  output logic              line_head,
  output logic              hsa_win,
  output logic              hbp_win,
  output logic              hfp_win,
  output logic              pix_busy,
  output logic              pix_start,
  output logic              null_busy,
  output logic              null_start,
  output logic              fetch_hit
);

  localparam int LW = ((H_W > NULL_W) ? H_W : NULL_W) + 1;
  localparam int AW = H_W + 1;

  logic [H_W-1:0] hcnt, hcnt_d;
  logic [AW-1:0]  act_start;
  logic           burst, null_on, start_now;
  logic [LW-1:0]  pix_len_m1, null_len_m1;
  hphase_e        phase, phase_d;
  logic [LW-1:0]  left, left_d;
  logic [H_W-1:0] chunks_left, chunks_left_d;

  assign act_start   = {1'b0, hsa} + {1'b0, hbp};
  assign line_end    = ({1'b0, hcnt} + 1'b1) >= {1'b0, line_time};
  assign burst       = (chunks == '0);
  assign null_on     = !burst && (null_size != '0);
  assign pix_len_m1  = LW'(pkt_span(32'(pkt_size)) - 1);
  assign null_len_m1 = LW'(pkt_span(32'(null_size)) - 1);

  always_comb begin
    if (!soft_rst_n)    hcnt_d = '0;
    else if (!run)      hcnt_d = hcnt;
    else if (line_end)  hcnt_d = '0;
    else                hcnt_d = hcnt + 1'b1;
  end

  assign start_now = active_nxt && ({1'b0, hcnt_d} == act_start);

  // Packet engine: steps on the position the line counter is about to take.
  always_comb begin
    phase_d       = phase;
    left_d        = left;
    chunks_left_d = chunks_left;
    if (start_now) begin
      phase_d       = PH_PIX;
      left_d        = pix_len_m1;
      chunks_left_d = burst ? '0 : chunks - 1'b1;
    end else if (hcnt_d == '0) begin
      phase_d       = PH_IDLE;
      left_d        = '0;
      chunks_left_d = '0;
    end else if (phase != PH_IDLE) begin
      if (left != '0) begin
        left_d = left - 1'b1;
      end else if (phase == PH_PIX && null_on) begin
        phase_d = PH_NULL;
        left_d  = null_len_m1;
      end else if (chunks_left != '0) begin
        phase_d       = PH_PIX;
        left_d        = pix_len_m1;
        chunks_left_d = chunks_left - 1'b1;
      end else begin
        phase_d = PH_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt        <= '0;
      phase       <= PH_IDLE;
      left        <= '0;
      chunks_left <= '0;
    end else begin
      hcnt        <= hcnt_d;
      phase       <= phase_d;
      left        <= left_d;
      chunks_left <= chunks_left_d;
    end
  end

  assign line_head  = (hcnt == '0);
  assign hsa_win    = (hcnt < hsa);
  assign hbp_win    = active_now && !hsa_win && ({1'b0, hcnt} < act_start);
  assign hfp_win    = active_now && ({1'b0, hcnt} >= act_start) && (phase == PH_IDLE);
  assign pix_busy   = (phase == PH_PIX);
  assign null_busy  = (phase == PH_NULL);
  assign pix_start  = pix_busy && (left == pix_len_m1);
  assign null_start = null_busy && (left == null_len_m1);
  assign fetch_hit  = active_now && (DLY_W'(hcnt) == fetch_dly);

  // R2
  hcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (({1'b0, hcnt} < {1'b0, line_time}) || (hcnt == '0)));

  // R4
  pix_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pix_start) |-> ({1'b0, hcnt} >= act_start));

  // R5
  null_after_pix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && null_start) |-> $past(pix_busy));

  // R6
  burst_no_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && burst) |-> !null_busy);

  // R7
  wrap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && line_head && !(active_now && act_start == '0))
      |-> (phase == PH_IDLE));

endmodule

// File: rtl/dsi_vid_seq.sv
module dsi_vid_seq
  import dsi_vseq_pkg::*;
#(
  parameter int H_W    = 16,
  parameter int V_W    = 10,
  parameter int VACT_W = 16,
  parameter int NULL_W = 10,
  parameter int DLY_W  = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst_n,
  input  logic [2*H_W-1:0]    cfg_hblank,
  input  logic [H_W-1:0]      cfg_line_time,
  input  logic [3*V_W-1:0]    cfg_vblank,
  input  logic [VACT_W-1:0]   cfg_vactive,
  input  logic [2*H_W-1:0]    cfg_pkt,
  input  logic [NULL_W-1:0]   cfg_null_size,
  input  logic [5:0]          cfg_lp_en,
  input  logic [DLY_W-1:0]    cfg_fetch_dly,
  output logic                line_start,
  output logic                frame_start,
  output logic [1:0]          vregion,
  output logic                hsync_win,
  output logic                hbp_win,
  output logic                hfp_win,
  output logic                pix_pkt_start,
  output logic                pix_pkt_busy,
  output logic                null_pkt_start,
  output logic                null_pkt_busy,
  output logic                lp_allowed,
  output logic                fetch_start
);

  logic               run;
  logic [H_W-1:0]     hsa, hbp, line_time, pkt_size, chunks;
  logic [V_W-1:0]     vsa, vbp, vfp;
  logic [VACT_W-1:0]  vact;
  logic [NULL_W-1:0]  null_size;
  logic [5:0]         lp_en;
  logic [DLY_W-1:0]   fetch_dly;
  vreg_e              vreg, vreg_nxt;
  logic               frame_head, line_end, line_head;
  logic               hsa_w, hbp_w, hfp_w, pix_b, pix_s, null_b, null_s, fetch_h;
  logic               is_act, blank_en;

  vseq_cfg #(.H_W(H_W), .V_W(V_W), .VACT_W(VACT_W), .NULL_W(NULL_W), .DLY_W(DLY_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .soft_rst_n(soft_rst_n),
    .cfg_hblank(cfg_hblank), .cfg_line_time(cfg_line_time), .cfg_vblank(cfg_vblank),
    .cfg_vactive(cfg_vactive), .cfg_pkt(cfg_pkt), .cfg_null_size(cfg_null_size),
    .cfg_lp_en(cfg_lp_en), .cfg_fetch_dly(cfg_fetch_dly),
    .run(run), .hsa(hsa), .hbp(hbp), .line_time(line_time),
    .vsa(vsa), .vbp(vbp), .vfp(vfp), .vact(vact),
    .pkt_size(pkt_size), .chunks(chunks), .null_size(null_size),
    .lp_en(lp_en), .fetch_dly(fetch_dly)
  );

  vseq_vert #(.V_W(V_W), .VACT_W(VACT_W)) u_vert (
    .clk(clk), .rst_n(rst_n), .soft_rst_n(soft_rst_n), .run(run), .line_end(line_end),
    .vsa(vsa), .vbp(vbp), .vact(vact), .vfp(vfp),
    .vreg(vreg), .vreg_nxt(vreg_nxt), .frame_head(frame_head)
  );

  vseq_horiz #(.H_W(H_W), .NULL_W(NULL_W), .DLY_W(DLY_W)) u_horiz (
    .clk(clk), .rst_n(rst_n), .soft_rst_n(soft_rst_n), .run(run),
    .active_now(vreg == VR_ACT), .active_nxt(vreg_nxt == VR_ACT),
    .hsa(hsa), .hbp(hbp), .line_time(line_time), .pkt_size(pkt_size),
    .chunks(chunks), .null_size(null_size), .fetch_dly(fetch_dly),
    .line_end(line_end), .line_head(line_head),
    .hsa_win(hsa_w), .hbp_win(hbp_w), .hfp_win(hfp_w),
    .pix_busy(pix_b), .pix_start(pix_s), .null_busy(null_b), .null_start(null_s),
    .fetch_hit(fetch_h)
  );

  assign is_act = (vreg == VR_ACT);

  always_comb begin
    case (vreg)
      VR_SYNC:  blank_en = lp_en[0];
      VR_BACK:  blank_en = lp_en[1];
      VR_FRONT: blank_en = lp_en[2];
      default:  blank_en = 1'b0;
    endcase
  end

  assign line_start     = run && line_head;
  assign frame_start    = run && line_head && frame_head;
  assign vregion        = vreg;
  assign hsync_win      = run && hsa_w;
  assign hbp_win        = run && hbp_w;
  assign hfp_win        = run && hfp_w;
  assign pix_pkt_start  = run && pix_s;
  assign pix_pkt_busy   = run && pix_b;
  assign null_pkt_start = run && null_s;
  assign null_pkt_busy  = run && null_b;
  assign fetch_start    = run && fetch_h;
  assign lp_allowed     = run && (is_act
                          ? (lp_en[3] && ((hbp_w && lp_en[4]) || (hfp_w && lp_en[5])))
                          : (!hsa_w && blank_en));

  // R12
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !(line_start || frame_start || pix_pkt_start || null_pkt_start ||
               fetch_start || lp_allowed));

  // R10
  fetch_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start |-> (vregion == 2'd2));

  // R8
  lp_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !is_act && hsync_win) |-> !lp_allowed);

endmodule

// File: tb/sim_dsi_vid_seq.sv
module sim_dsi_vid_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst_n = 1'b0;
  logic [31:0] cfg_hblank = '0;
  logic [15:0] cfg_line_time = '0;
  logic [29:0] cfg_vblank = '0;
  logic [15:0] cfg_vactive = '0;
  logic [31:0] cfg_pkt = '0;
  logic [9:0]  cfg_null_size = '0;
  logic [5:0]  cfg_lp_en = '0;
  logic [23:0] cfg_fetch_dly = '0;
  logic line_start, frame_start, hsync_win, hbp_win, hfp_win;
  logic pix_pkt_start, pix_pkt_busy, null_pkt_start, null_pkt_busy;
  logic lp_allowed, fetch_start;
  logic [1:0] vregion;

  always #2 clk = ~clk;

  dsi_vid_seq u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst_n(soft_rst_n),
    .cfg_hblank(cfg_hblank), .cfg_line_time(cfg_line_time), .cfg_vblank(cfg_vblank),
    .cfg_vactive(cfg_vactive), .cfg_pkt(cfg_pkt), .cfg_null_size(cfg_null_size),
    .cfg_lp_en(cfg_lp_en), .cfg_fetch_dly(cfg_fetch_dly),
    .line_start(line_start), .frame_start(frame_start), .vregion(vregion),
    .hsync_win(hsync_win), .hbp_win(hbp_win), .hfp_win(hfp_win),
    .pix_pkt_start(pix_pkt_start), .pix_pkt_busy(pix_pkt_busy),
    .null_pkt_start(null_pkt_start), .null_pkt_busy(null_pkt_busy),
    .lp_allowed(lp_allowed), .fetch_start(fetch_start)
  );

  typedef struct { int cyc; int kind; } ev_t;
  ev_t q[$];

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  bit mon_on = 0;
  int cyc = 0;
  string tag = "";

  // model copy of the timing that the design should have latched
  int m_hsa, m_hbp, m_lt, m_vsa, m_vbp, m_vact, m_vfp, m_pkt, m_chunks, m_null, m_dly;
  bit [5:0] m_lp;

  function automatic string kind_req(int k);
    case (k)
      0: return "R2";
      1: return "R3";
      2: return "R10";
      3: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic int region_of(int line);
    int tot = m_vsa + m_vbp + m_vact + m_vfp;
    int f = line % tot;
    if (f < m_vsa) return 0;
    if (f < m_vsa + m_vbp) return 1;
    if (f < m_vsa + m_vbp + m_vact) return 2;
    return 3;
  endfunction

  function automatic int pkt_end();
    int a = m_hsa + m_hbp;
    if (m_chunks == 0) return a + m_pkt + 6;
    return a + m_chunks * (m_pkt + 6 + ((m_null != 0) ? m_null + 6 : 0));
  endfunction

  function automatic bit lp_model(int c);
    int line = c / m_lt;
    int h = c % m_lt;
    int r = region_of(line);
    int a = m_hsa + m_hbp;
    if (r != 2) begin
      if (h < m_hsa) return 1'b0;
      return m_lp[(r == 3) ? 2 : r];
    end
    return m_lp[3] && ((h >= m_hsa && h < a && m_lp[4]) ||
                       (h >= a && h >= pkt_end() && m_lp[5]));
  endfunction

  task automatic add_ev(int c, int k, int window);
    ev_t e;
    if (c < window) begin
      e.cyc = c;
      e.kind = k;
      q.push_back(e);
    end
  endtask

  // Driver: fill the scoreboard with the events the requirements predict.
  task automatic push_events(int window);
    int tot = m_vsa + m_vbp + m_vact + m_vfp;
    for (int line = 0; line * m_lt < window; line++) begin
      int base = line * m_lt;
      int t = m_hsa + m_hbp;
      add_ev(base, 0, window);
      if (line % tot == 0) add_ev(base, 1, window);
      if (region_of(line) == 2) begin
        if (m_dly < m_lt) add_ev(base + m_dly, 2, window);
        if (m_chunks == 0) begin
          if (t < m_lt) add_ev(base + t, 3, window);
        end else begin
          for (int k = 0; k < m_chunks; k++) begin
            if (t < m_lt) add_ev(base + t, 3, window);
            t += m_pkt + 6;
            if (m_null != 0) begin
              if (t < m_lt) add_ev(base + t, 4, window);
              t += m_null + 6;
            end
          end
        end
      end
    end
  endtask

  task automatic check_kind(logic strobe, int k);
    bit found = 0;
    if (strobe) begin
      checks++;
      for (int i = 0; i < q.size(); i++) begin
        if (!found && q[i].cyc == cyc && q[i].kind == k) begin
          q.delete(i);
          found = 1;
        end
      end
      if (!found) begin
        fails++;
        $display("FAIL %s %s: event kind %0d at cycle %0d act=present exp=absent",
                 kind_req(k), tag, k, cyc);
      end
    end
  endtask

  // Monitor
  always @(negedge clk) begin
    if (mon_on) begin
      bit exp_lp;
      int line;
      line = cyc / m_lt;
      check_kind(line_start, 0);
      check_kind(frame_start, 1);
      check_kind(fetch_start, 2);
      check_kind(pix_pkt_start, 3);
      check_kind(null_pkt_start, 4);
      exp_lp = lp_model(cyc);
      checks++;
      if (lp_allowed !== exp_lp) begin
        fails++;
        $display("FAIL %s %s: lp_allowed at cycle %0d act=%0b exp=%0b",
                 (region_of(line) == 2) ? "R9" : "R8", tag, cyc, lp_allowed, exp_lp);
      end
      if (cyc % m_lt == 0) begin
        checks++;
        if (int'(vregion) != region_of(line)) begin
          fails++;
          $display("FAIL R3 %s: vregion line %0d act=%0d exp=%0d",
                   tag, line, vregion, region_of(line));
        end
      end
      cyc++;
    end
  end

  task automatic check_quiet(string req);
    checks++;
    if (line_start || frame_start || pix_pkt_start || null_pkt_start ||
        fetch_start || lp_allowed || pix_pkt_busy || null_pkt_busy ||
        hsync_win || hbp_win || hfp_win) begin
      fails++;
      $display("FAIL %s: outputs while stopped act=active exp=all zero", req);
    end
  endtask

  task automatic set_cfg(int hsa, int hbp, int lt, int vsa, int vbp, int vact, int vfp,
                         int pkt, int chn, int nul, bit [5:0] lp, int dly);
    m_hsa = hsa; m_hbp = hbp; m_lt = lt; m_vsa = vsa; m_vbp = vbp; m_vact = vact;
    m_vfp = vfp; m_pkt = pkt; m_chunks = chn; m_null = nul; m_lp = lp; m_dly = dly;
    cfg_hblank    = {16'(hsa), 16'(hbp)};
    cfg_line_time = 16'(lt);
    cfg_vblank    = {10'(vsa), 10'(vbp), 10'(vfp)};
    cfg_vactive   = 16'(vact);
    cfg_pkt       = {16'(chn), 16'(pkt)};
    cfg_null_size = 10'(nul);
    cfg_lp_en     = lp;
    cfg_fetch_dly = 24'(dly);
  endtask

  task automatic run_case(string name, int window, bit scramble);
    tag = name;
    q.delete();
    push_events(window);
    repeat (3) @(posedge clk);
    @(negedge clk);
    soft_rst_n = 1'b1;
    @(posedge clk);
    cyc = 0;
    mon_on = 1;
    if (scramble) begin
      // R11: inputs change while running; latched timing must persist
      #1;
      cfg_hblank = 32'h0003_0009;
      cfg_line_time = 16'd17;
      cfg_vblank = '1;
      cfg_pkt = 32'h0002_0003;
      cfg_lp_en = 6'b010101;
      cfg_fetch_dly = 24'd3;
    end
    wait (cyc == window);
    mon_on = 0;
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL %s %s: missed events act=%0d exp=0 first kind %0d at cycle %0d",
               kind_req(q[0].kind), name, q.size(), q[0].kind, q[0].cyc);
    end
    @(negedge clk);
    soft_rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check_quiet("R11 soft reset stop");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_quiet("R12 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_quiet("R12 soft reset held");

    // R1 R5: chunked lines, null packets after each chunk, all LP enables on
    set_cfg(4, 3, 80, 1, 1, 2, 1, 10, 3, 2, 6'b111111, 5);
    run_case("R1 R5 chunked", 800, 1'b0);

    // R6 R11: burst, non-zero null ignored, zero sync region skipped, scrambled inputs
    set_cfg(2, 0, 50, 0, 2, 3, 0, 20, 0, 5, 6'b101010, 100);
    run_case("R6 R11 burst", 500, 1'b1);

    // R7: packet at line start, overrun cut off, zero porch regions
    set_cfg(0, 0, 30, 0, 0, 2, 1, 10, 4, 0, 6'b011100, 0);
    run_case("R7 overrun", 180, 1'b0);

    // R9: active-line LP only in front porch, several null packets
    set_cfg(3, 5, 64, 2, 0, 3, 2, 6, 2, 4, 6'b101001, 12);
    run_case("R9 hfp only", 640, 1'b0);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL R2 watchdog act=running exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule